// File: doc/BRIEF.md
# Periodic Performance Counter Collector

This block sits beside a processor core and keeps four 64-bit event counters. Counter 0 counts clock cycles and counter 1 counts retired instructions, each through its own strobe input. Counters 2 and 3 each pick one line out of a 128-line event bus through a 7-bit selector. Software never reads the counters directly, and the block has no interrupt. A sampling timer instead starts a collection pass at a programmed interval. Each pass adds every counter's value into a 64-bit accumulation word in memory.

A pass captures all four counters in one cycle and clears them in that same cycle, so each pass adds only the counts gathered since the previous pass. It then does a read-modify-write on each of four consecutive memory words, starting at a programmed base address. Memory therefore always holds a running total, and software may read it at any time. Collection is started and stopped through a small register write port. A stop request flushes the counts still held before the block goes quiet.

Top module: `perf_collector`

## Requirements
- R1: While collection is active, counter 0 counts the cycles in which `cyc_strobe_i` is high and counter 1 counts the cycles in which `ins_strobe_i` is high. Collection is active from the cycle after a start is accepted through the cycle in which a stop is accepted.
- R2: Counter 2 counts the cycles in which `evt_i[S2]` is high and counter 3 counts the cycles in which `evt_i[S3]` is high. S2 is taken from bits [6:0] and S3 from bits [14:8] of a write to register address 3.
- R3: A write to register address 1 sets the sampling period P, with 0 treated as 1. While no pass overruns, consecutive passes begin exactly P cycles apart.
- R4: A pass handles the counters in index order 0 to 3. For counter i it first reads the word at base + 8*i, then writes the read value plus the captured count back to the same address. Each request holds `mem_req_o`, the address, the direction and the data stable until `mem_ack_i` is seen. The base comes from register address 2, with its low three bits ignored.
- R5: A counter is captured and cleared in the same cycle, and an event in that cycle goes into the next interval. The total added to memory over all passes of a run therefore equals the events counted between start and stop.
- R6: If the timer expires while a pass is in progress, `overrun_o` is set and stays set until the next accepted start. A deferred pass is also started as soon as the current pass ends.
- R7: A write to register address 0 with bit 1 set stops collection. The block first completes any pass in progress, then runs one final pass that flushes the remaining counts. After that `running_o` falls and no further memory requests are made.
- R8: Writes to register addresses 2 and 3 made during collection do not take effect until the next pass capture. They also take effect when collection starts.
- R9: After reset, `running_o`, `pass_busy_o`, `overrun_o` and `mem_req_o` are low.
- R10: A write to register address 0 with bit 0 set, made while the block is idle, clears the counters and `overrun_o` and starts collection. `mem_req_o` stays low whenever `running_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_strobe_i | input | 1 | Core cycle strobe |
| ins_strobe_i | input | 1 | Retired instruction strobe |
| evt_i | input | 128 | Event lines for the selectable counters |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register address: 0 control, 1 period, 2 base, 3 selectors |
| cfg_wdata_i | input | 64 | Register write data |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the accumulation word |
| mem_wdata_o | output | 64 | Write data (old word plus count) |
| mem_ack_i | input | 1 | One-cycle acknowledge; read data is valid in the same cycle |
| mem_rdata_i | input | 64 | Read data |
| running_o | output | 1 | Collection active or still draining |
| pass_busy_o | output | 1 | A collection pass is in progress |
| overrun_o | output | 1 | Sticky flag: the timer expired during a pass |

## Verification
The hardest situations to reach from the ports are the ones where a pass overlaps something else: a timer expiry arriving during a pass, and a configuration write landing between two pass boundaries. To force overruns, the stimulus uses a period shorter than a pass and stretches the memory acknowledge latency at random. Separately, it uses a period far longer than the run, so that the final pass triggered by the stop is the only pass boundary. Updates to the base and selectors made mid-run must then land in the new memory region, counted under the old selectors. Randomized runs mix periods, latencies and event densities. Each run ends by comparing both memory regions against totals the bench accumulates from the events it drove.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int NUM_CTR  = 4;
  localparam int NUM_PROG = NUM_CTR - 2;
  localparam int FIELD_STRIDE = 8;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_BASE   = 2'd2,
    REG_SEL    = 2'd3
  } reg_id_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_READ  = 2'd1,
    PS_WRITE = 2'd2
  } pass_st_e;
endpackage

// File: rtl/pc_event_mux.sv
module pc_event_mux #(
  parameter int SEL_W = 7,
  localparam int NUM_EVT = 1 << SEL_W
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               hit_o
);
  assign hit_o = evt_i[sel_i];
endmodule

// File: rtl/pc_counter.sv
module pc_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic          hit_i,
  input  logic          capture_i,
  output logic [CW-1:0] cnt_o
);
  logic bump;
  assign bump = en_i && hit_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i)  cnt_o <= '0;
    else if (capture_i)  cnt_o <= CW'(bump);
    else if (bump)       cnt_o <= cnt_o + CW'(1);
  end

  // R5: after a capture the counter restarts from at most one event
  p_capture_restart_r5: assert property (@(posedge clk) disable iff (rst)
    capture_i && !clear_i |=> cnt_o <= CW'(1));
  // R1: with counting disabled and no capture the value holds
  p_hold_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en_i && !capture_i && !clear_i |=> $stable(cnt_o));
endmodule

// File: rtl/pc_sample_timer.sv
module pc_sample_timer #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [PW-1:0] period_i,
  output logic          expire_o
);
  logic [PW-1:0] tcnt_q;
  logic [PW-1:0] limit;

  assign limit = (period_i == '0) ? PW'(1) : period_i;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      tcnt_q   <= '0;
      expire_o <= 1'b0;
    end else if (tcnt_q >= limit - PW'(1)) begin
      tcnt_q   <= '0;
      expire_o <= 1'b1;
    end else begin
      tcnt_q   <= tcnt_q + PW'(1);
      expire_o <= 1'b0;
    end
  end

  // R3: no expiry pulse once the timer is halted
  p_quiet_when_halted_r3: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !expire_o);
  // R3: periods above one never give back-to-back expiries
  p_expiry_gap_r3: assert property (@(posedge clk) disable iff (rst)
    expire_o && run_i && period_i > PW'(1) |=> !expire_o);
endmodule

// File: rtl/pc_pass_engine.sv
module pc_pass_engine import pc_pkg::*; #(
  parameter int CW = 64,
  parameter int AW = 32,
  parameter int NC = 4,
  localparam int IW = (NC > 1) ? $clog2(NC) : 1,
  localparam int WB = CW / 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  capture_i,
  input  logic [NC-1:0][CW-1:0] cnt_i,
  input  logic [AW-1:0]         base_i,
  input  logic                  mem_ack_i,
  input  logic [CW-1:0]         mem_rdata_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [CW-1:0]         mem_wdata_o
);
  localparam logic [AW-1:0] LOW_MASK = AW'(WB - 1);

  pass_st_e      st_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] snap_q [NC];

  assign busy_o = (st_q != PS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= PS_IDLE;
      idx_q       <= '0;
      base_q      <= '0;
      done_o      <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        PS_IDLE: if (capture_i) begin
          for (int k = 0; k < NC; k++) snap_q[k] <= cnt_i[k];
          base_q     <= base_i & ~LOW_MASK;
          idx_q      <= '0;
          mem_addr_o <= base_i & ~LOW_MASK;
          mem_we_o   <= 1'b0;
          mem_req_o  <= 1'b1;
          st_q       <= PS_READ;
        end
        PS_READ: if (mem_ack_i) begin
          mem_wdata_o <= mem_rdata_i + snap_q[idx_q];
          mem_we_o    <= 1'b1;
          st_q        <= PS_WRITE;
        end
        PS_WRITE: if (mem_ack_i) begin
          mem_we_o <= 1'b0;
          if (idx_q == IW'(NC - 1)) begin
            mem_req_o <= 1'b0;
            done_o    <= 1'b1;
            st_q      <= PS_IDLE;
          end else begin
            idx_q      <= idx_q + IW'(1);
            mem_addr_o <= base_q + (AW'(idx_q) + AW'(1)) * AW'(WB);
            st_q       <= PS_READ;
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  // R4: an unacknowledged request keeps every field steady
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                               && $stable(mem_we_o) && $stable(mem_wdata_o));
  // R4: an acknowledged read is followed by a write to the same word
  p_read_then_write_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_ack_i && !mem_we_o |=> mem_req_o && mem_we_o && $stable(mem_addr_o));
  // R3: a capture is only offered to an idle engine
  p_capture_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
    capture_i |-> !busy_o);
endmodule

// File: rtl/perf_collector.sv
module perf_collector import pc_pkg::*; #(
  parameter int CW    = 64,
  parameter int AW    = 32,
  parameter int PW    = 32,
  parameter int SEL_W = 7,
  localparam int NUM_EVT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_strobe_i,
  input  logic               ins_strobe_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [CW-1:0]      cfg_wdata_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [CW-1:0]      mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [CW-1:0]      mem_rdata_i,
  output logic               running_o,
  output logic               pass_busy_o,
  output logic               overrun_o
);
  logic run_q, stop_q, final_q, pend_q, ovr_q;
  logic [PW-1:0]    period_q;
  logic [AW-1:0]    base_pend_q;
  logic [SEL_W-1:0] sel_pend_q [NUM_PROG];
  logic [SEL_W-1:0] sel_act_q  [NUM_PROG];

  logic ctrl_wr, start_acc, stop_acc, count_en, capture;
  logic expire, eng_busy, eng_done;
  logic [NUM_CTR-1:0][CW-1:0] cnt_w;
  logic unused_cfg;

  assign unused_cfg = ^cfg_wdata_i;
  assign ctrl_wr   = cfg_we_i && (cfg_addr_i == REG_CTRL);
  assign start_acc = ctrl_wr && cfg_wdata_i[0] && !run_q;
  assign stop_acc  = ctrl_wr && cfg_wdata_i[1] && run_q && !stop_q;
  assign count_en  = run_q && !stop_q;
  assign capture   = run_q && !eng_busy && (stop_q ? !final_q : (expire || pend_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      stop_q      <= 1'b0;
      final_q     <= 1'b0;
      pend_q      <= 1'b0;
      ovr_q       <= 1'b0;
      period_q    <= '0;
      base_pend_q <= '0;
      for (int k = 0; k < NUM_PROG; k++) begin
        sel_pend_q[k] <= '0;
        sel_act_q[k]  <= '0;
      end
    end else begin
      if (cfg_we_i) begin
        case (cfg_addr_i)
          REG_PERIOD: period_q    <= cfg_wdata_i[PW-1:0];
          REG_BASE:   base_pend_q <= cfg_wdata_i[AW-1:0];
          REG_SEL: for (int k = 0; k < NUM_PROG; k++)
                     sel_pend_q[k] <= cfg_wdata_i[FIELD_STRIDE*k +: SEL_W];
          default: ;
        endcase
      end
      if (start_acc) begin
        run_q   <= 1'b1;
        stop_q  <= 1'b0;
        final_q <= 1'b0;
        pend_q  <= 1'b0;
        ovr_q   <= 1'b0;
        for (int k = 0; k < NUM_PROG; k++) sel_act_q[k] <= sel_pend_q[k];
      end else begin
        if (stop_acc) begin
          stop_q <= 1'b1;
          pend_q <= 1'b0;
        end
        if (capture) begin
          pend_q <= 1'b0;
          for (int k = 0; k < NUM_PROG; k++) sel_act_q[k] <= sel_pend_q[k];
          if (stop_q) final_q <= 1'b1;
        end else if (expire && eng_busy && !stop_q && !stop_acc) begin
          pend_q <= 1'b1;
          ovr_q  <= 1'b1;
        end
        if (eng_done && final_q) begin
          run_q   <= 1'b0;
          stop_q  <= 1'b0;
          final_q <= 1'b0;
        end
      end
    end
  end

  pc_sample_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst(rst), .run_i(count_en), .period_i(period_q), .expire_o(expire)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic hit;
    if (i == 0) begin : g_cyc
      assign hit = cyc_strobe_i;
    end else if (i == 1) begin : g_ins
      assign hit = ins_strobe_i;
    end else begin : g_evt
      pc_event_mux #(.SEL_W(SEL_W)) u_mux (
        .evt_i(evt_i), .sel_i(sel_act_q[i-2]), .hit_o(hit)
      );
    end
    pc_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .clear_i(start_acc), .en_i(count_en),
      .hit_i(hit), .capture_i(capture), .cnt_o(cnt_w[i])
    );
  end

  pc_pass_engine #(.CW(CW), .AW(AW), .NC(NUM_CTR)) u_engine (
    .clk(clk), .rst(rst), .capture_i(capture), .cnt_i(cnt_w), .base_i(base_pend_q),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .busy_o(eng_busy),
    .done_o(eng_done), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  assign running_o   = run_q;
  assign pass_busy_o = eng_busy;
  assign overrun_o   = ovr_q;

  // R10: no memory traffic while collection is off
  p_no_req_stopped_r10: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !mem_req_o);
  // R6: the overrun flag only drops on an accepted start
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ovr_q && !start_acc |=> ovr_q);
  // R7: collection halts only with the engine drained
  p_drain_before_halt_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> !eng_busy && !mem_req_o);
  // R8: active selectors move only at a capture or a start
  p_sel_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    !capture && !start_acc |=> $stable(sel_act_q[0]) && $stable(sel_act_q[1]));
endmodule

// File: tb/perf_collector_test.sv
module perf_collector_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cyc_strobe = 1'b0, ins_strobe = 1'b0;
  logic [127:0] evt = '0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [63:0]  cfg_wdata = '0;
  logic         mem_req, mem_we, mem_ack;
  logic [31:0]  mem_addr;
  logic [63:0]  mem_wdata, mem_rdata;
  logic         running, busy, overrun;

  perf_collector uut (
    .clk(clk), .rst(rst), .cyc_strobe_i(cyc_strobe), .ins_strobe_i(ins_strobe),
    .evt_i(evt), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .running_o(running), .pass_busy_o(busy), .overrun_o(overrun)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model with random acknowledge latency and access-order tracking
  logic [63:0] mem [128];
  logic [63:0] exp_mem [128];
  int max_lat = 0, wait_cnt = 0, ord_i = 0, ord_viol = 0;
  bit ord_we = 0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; mem_rdata <= '0; wait_cnt = 0; ord_i = 0; ord_we = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack <= 1'b1;
        if (mem_we != ord_we || mem_addr[4:3] != 2'(ord_i) || mem_addr[2:0] != 3'd0) ord_viol++;
        if (mem_we) begin
          mem[mem_addr[9:3]] = mem_wdata;
          ord_we = 0; ord_i = (ord_i + 1) % 4;
        end else begin
          mem_rdata <= mem[mem_addr[9:3]];
          ord_we = 1;
        end
        wait_cnt = (max_lat == 0) ? 0 : $urandom_range(max_lat);
      end else wait_cnt--;
    end
  end

  // stimulus state and reference totals
  bit counting = 0, ev_on = 1;
  int dens = 50, cycle_no = 0, rise_prev = 0, rise_last = 0, nrise = 0;
  bit prev_busy = 0;
  logic [63:0] exp_cnt [4];
  logic [6:0]  cur_sel [2];
  int cur_base = 32'h100;

  task automatic step(input logic we, input logic [1:0] a, input logic [63:0] d);
    logic c, n;
    logic [127:0] e;
    c = ev_on && ($urandom_range(99) < dens);
    n = ev_on && ($urandom_range(99) < dens);
    e = ev_on ? {$urandom(), $urandom(), $urandom(), $urandom()} : '0;
    if (counting) begin
      exp_cnt[0] += 64'(c);
      exp_cnt[1] += 64'(n);
      exp_cnt[2] += 64'(e[cur_sel[0]]);
      exp_cnt[3] += 64'(e[cur_sel[1]]);
    end
    cyc_strobe = c; ins_strobe = n; evt = e;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cycle_no++;
    if (busy && !prev_busy) begin
      rise_prev = rise_last; rise_last = cycle_no; nrise++;
    end
    prev_busy = busy;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0);
  endtask

  task automatic start_run(input bit cfg, input int period, input int base, input int s0, input int s1);
    if (cfg) begin
      step(1'b1, 2'd1, 64'(period));
      step(1'b1, 2'd2, 64'(base));
      step(1'b1, 2'd3, 64'((s1 << 8) | s0));
      cur_base = base; cur_sel[0] = 7'(s0); cur_sel[1] = 7'(s1);
    end
    for (int i = 0; i < 4; i++) exp_cnt[i] = '0;
    step(1'b1, 2'd0, 64'h1);
    counting = 1;
    nrise = 0;
  endtask

  task automatic stop_and_check(input string tag);
    int guard;
    step(1'b1, 2'd0, 64'h2);
    counting = 0;
    guard = 0;
    while (running && guard < 3000) begin step(1'b0, 2'd0, '0); guard++; end
    chk(!running, "R7 running_o falls after stop", 64'(running), 64'd0);
    for (int i = 0; i < 4; i++) exp_mem[cur_base/8 + i] += exp_cnt[i];
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 4; i++)
        chk(mem[32*(r+1) + i] == exp_mem[32*(r+1) + i],
            $sformatf("%s word %0d (R1 R2 R5)", tag, 32*(r+1) + i),
            mem[32*(r+1) + i], exp_mem[32*(r+1) + i]);
    guard = 0;
    for (int i = 0; i < 20; i++) begin
      if (mem_req) guard++;
      step(1'b0, 2'd0, '0);
    end
    chk(guard == 0, "R7 R10 no requests after halt", 64'(guard), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 128; i++) begin
      mem[i] = {$urandom(), $urandom()};
      exp_mem[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!running, "R9 running_o after reset", 64'(running), 0);
    chk(!busy, "R9 pass_busy_o after reset", 64'(busy), 0);
    chk(!overrun, "R9 overrun_o after reset", 64'(overrun), 0);
    chk(!mem_req, "R10 mem_req_o while stopped", 64'(mem_req), 0);

    // R3 periodic passes with a short pass, no overrun
    max_lat = 0;
    start_run(1, 40, 32'h100, 3, 77);
    idle(220);
    chk(nrise >= 3, "R3 passes occurred", 64'(nrise), 3);
    chk(rise_last - rise_prev == 40, "R3 pass interval", 64'(rise_last - rise_prev), 40);
    chk(!overrun, "R6 no overrun with long period", 64'(overrun), 0);
    stop_and_check("directed");
    chk(ord_viol == 0, "R4 access order", 64'(ord_viol), 0);

    // R6 overrun: period shorter than a pass, slow memory
    max_lat = 3;
    start_run(1, 4, 32'h200, 127, 0);
    idle(150);
    chk(overrun, "R6 overrun set", 64'(overrun), 1);
    stop_and_check("overrun");
    chk(overrun, "R6 overrun sticky after stop", 64'(overrun), 1);
    start_run(0, 0, 0, 0, 0);
    chk(!overrun, "R10 R6 start clears overrun", 64'(overrun), 0);
    idle(50);
    stop_and_check("restart");

    // R8 base and selector writes take effect at the next capture
    max_lat = 1;
    start_run(1, 2000, 32'h100, 5, 9);
    idle(80);
    step(1'b1, 2'd2, 64'h200);
    step(1'b1, 2'd3, 64'((21 << 8) | 20));
    idle(80);
    cur_base = 32'h200;
    stop_and_check("R8 deferred");
    cur_sel[0] = 7'd20; cur_sel[1] = 7'd21;
    start_run(0, 0, 0, 0, 0);
    idle(60);
    stop_and_check("R8 applied at start");

    // randomized runs
    for (int r = 0; r < 4; r++) begin
      max_lat = $urandom_range(3);
      dens = $urandom_range(90, 5);
      start_run(1, $urandom_range(60, 5), (r % 2) ? 32'h200 : 32'h100,
                $urandom_range(127), $urandom_range(127));
      idle($urandom_range(1200, 300));
      stop_and_check($sformatf("random run %0d", r));
    end
    chk(ord_viol == 0, "R4 access order over all runs", 64'(ord_viol), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule